// File: doc/BRIEF.md
# I2C GPIO Expander Target

This block is an I2C target that gives a host control of a parameterised set of general-purpose pins. The pin count is 8, 16, 32 or 64. The host reaches a byte-wide register file through SMBus byte-data transfers. Through it the host sets each pin's direction, drives the level of output pins, reads the level present on every pin and enables per-pin change interrupts. A single active-high request line signals the host when an enabled pin has changed.

A write transfer is: start, device address with the write bit, offset byte, one or more data bytes, stop. A read transfer is: start, device address with the write bit, offset byte, repeated start, device address with the read bit, one or more data bytes, stop. The host acknowledges every data byte except the last, which it does not acknowledge.

The offset selects a function bank and a byte within that bank. The bank shift is log2(N)-3, so every function occupies a contiguous run of N/8 bytes. The SCL, SDA and pin inputs each pass through a two-flop synchroniser in the system clock domain. The system clock must run well above the SCL rate. The block never stretches the clock.

Top module: `gpio_expander_i2c`

## Requirements
- R1: After reset, all pins are inputs (`pinOe` = 0), the driven value `pinOut` is 0, all interrupt enables are 0 and `irqOut` is low.
- R2: The block acknowledges only its own 7-bit address `DEV_ADDR`. After any other address it leaves SDA released for the whole transfer and changes no register.
- R3: Offset bits [7:SHIFT] select the function, where SHIFT = log2(N)-3:
  - 0 = direction
  - 1 = pin level
  - 2 = interrupt enable
  - 3 = change status

  Offset bits [SHIFT-1:0] select the byte. Pin p sits in byte p/8, at bit p%8.
- R4: A direction bit of 1 makes its pin an output (`pinOe` bit high). A bit of 0 makes it an input.
- R5: Writing the pin-level function sets the driven value `pinOut`. Reading it returns the synchronised pin levels.
- R6: A status bit sets when its synchronised pin changes level. Host writes to the status function have no effect.
- R7: Reading a status byte returns its current value and clears the bits of that byte.
- R8: `irqOut` is high exactly when some pin has both its status bit and its enable bit set. It follows that condition one cycle later.
- R9: Offsets whose function index is 4 or more read as 0x00 and ignore writes.
- R10: Within one transfer, the offset advances by one after each data byte, for both reads and writes.
- R11: The block only ever pulls SDA low. It changes its SDA drive only while SCL is low.
- R12: Pin levels that are already present when reset is released do not set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | Pulls SDA low when high |
| pinIn | input | NUM_PINS | Pad levels of the pins |
| pinOut | output | NUM_PINS | Driven value for output pins |
| pinOe | output | NUM_PINS | Output enable per pin |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- The SDA drive changes only after SCL has been seen low.
- Direction and enable bits move only on a write strobe.
- Status bits fall only on a read strobe.
- The request never rises without some enable set.

Other properties can only be shown by the bench's transfer scenarios against its register model:
- the address decode across banks;
- the per-pin change capture, including changes caused by flipping direction;
- clear-on-read;
- offset auto-increment in bursts;
- the silence of the reserved banks.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam logic [7:0] FN_DIR   = 8'd0;
  localparam logic [7:0] FN_LEVEL = 8'd1;
  localparam logic [7:0] FN_IEN   = 8'd2;
  localparam logic [7:0] FN_STAT  = 8'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_OFFS, S_WDATA, S_ACK, S_RDATA, S_MACK
  } busState_t;

  typedef struct packed {
    logic       wrEn;
    logic       rdLoad;
    logic [7:0] addr;
    logic [7:0] wdata;
  } ctlStrobe_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= {WIDTH{RST_VAL}};
      q    <= {WIDTH{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [7:0] rdByte,
  output ctlStrobe_t stb,
  output logic       sdaOe
);
  busState_t  state, nxtState;
  logic       sclPrev, sdaPrev, mAck;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txReg, offReg;
  logic       sclRise, sclFall, startDet, stopDet, byteDone, loadNow;

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign loadNow  = sclFall && (((state == S_ACK) && (nxtState == S_RDATA)) ||
                                ((state == S_MACK) && mAck));

  always_comb begin
    stb.addr   = offReg;
    stb.wdata  = shReg;
    stb.wrEn   = (state == S_WDATA) && byteDone;
    stb.rdLoad = loadNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      nxtState <= S_IDLE;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      mAck     <= 1'b0;
      bitCnt   <= '0;
      shReg    <= '0;
      txReg    <= '0;
      offReg   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (startDet) begin
        state  <= S_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else if (loadNow) begin
        txReg  <= rdByte;
        sdaOe  <= ~rdByte[7];
        bitCnt <= 4'd1;
        offReg <= offReg + 8'd1;
        state  <= S_RDATA;
      end else begin
        case (state)
          S_ADDR, S_OFFS, S_WDATA: begin
            if (sclRise && (bitCnt < 4'd8)) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (byteDone) begin
              bitCnt <= '0;
              if (state == S_ADDR) begin
                if (shReg[7:1] == DEV_ADDR) begin
                  sdaOe    <= 1'b1;
                  state    <= S_ACK;
                  nxtState <= shReg[0] ? S_RDATA : S_OFFS;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sdaOe    <= 1'b1;
                state    <= S_ACK;
                nxtState <= S_WDATA;
                offReg   <= (state == S_OFFS) ? shReg : offReg + 8'd1;
              end
            end
          end
          S_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= nxtState;
            end
          end
          S_RDATA: begin
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= S_MACK;
              end else begin
                sdaOe  <= ~txReg[6];
                txReg  <= {txReg[6:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (sclRise) mAck <= ~sdaS;
            else if (sclFall) state <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // SDA drive only moves after SCL was seen low
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclS));

  // SDA is only driven during an acknowledge or a read data byte
  assert_sda_owner_R11: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state == S_ACK || state == S_RDATA));
endmodule

// File: rtl/gpx_datapath.sv
module gpx_datapath
  import gpx_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic [NUM_PINS-1:0] pinSync,
  output logic [7:0]          rdByte,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  localparam int BYTES = NUM_PINS / 8;
  localparam int SHIFT = $clog2(NUM_PINS) - 3;

  logic [NUM_PINS-1:0] dirReg, outReg, ieReg, statReg, pinPrev, chg, rdFlat;
  logic [1:0]          armCnt;
  logic [7:0]          fnSel, byteSel;

  assign fnSel   = stb.addr >> SHIFT;
  assign byteSel = stb.addr & 8'(BYTES - 1);
  assign chg     = (armCnt == 2'd3) ? (pinSync ^ pinPrev) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armCnt  <= '0;
      pinPrev <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
      pinPrev <= pinSync;
      irqOut  <= |(statReg & ieReg);
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] dirB, outB, ieB, statB, rdB;
    logic       hit;
    assign hit = (byteSel == 8'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirB  <= '0;
        outB  <= '0;
        ieB   <= '0;
        statB <= '0;
      end else begin
        if (stb.wrEn && hit) begin
          case (fnSel)
            FN_DIR:   dirB <= stb.wdata;
            FN_LEVEL: outB <= stb.wdata;
            FN_IEN:   ieB  <= stb.wdata;
            default:  ;
          endcase
        end
        if (stb.rdLoad && hit && (fnSel == FN_STAT))
          statB <= chg[b*8 +: 8];
        else
          statB <= statB | chg[b*8 +: 8];
      end
    end

    always_comb begin
      rdB = '0;
      if (hit) begin
        case (fnSel)
          FN_DIR:   rdB = dirB;
          FN_LEVEL: rdB = pinSync[b*8 +: 8];
          FN_IEN:   rdB = ieB;
          FN_STAT:  rdB = statB;
          default:  rdB = '0;
        endcase
      end
    end

    assign dirReg[b*8 +: 8]  = dirB;
    assign outReg[b*8 +: 8]  = outB;
    assign ieReg[b*8 +: 8]   = ieB;
    assign statReg[b*8 +: 8] = statB;
    assign rdFlat[b*8 +: 8]  = rdB;
  end

  always_comb begin
    rdByte = '0;
    for (int b = 0; b < BYTES; b++) rdByte = rdByte | rdFlat[b*8 +: 8];
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;

  // request needs an enable that was set
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> |$past(ieReg));

  // direction only moves on a write strobe
  assert_dir_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dirReg) |-> $past(stb.wrEn));

  // enables only move on a write strobe
  assert_ien_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ieReg) |-> $past(stb.wrEn));

  // a status bit can only drop on a read strobe
  assert_stat_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statReg) & ~statReg)) |-> $past(stb.rdLoad));
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c
  import gpx_pkg::*;
#(
  parameter int         NUM_PINS = 16,
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  logic                sclS, sdaS;
  logic [NUM_PINS-1:0] pinSync;
  logic [7:0]          rdByte;
  ctlStrobe_t          stb;

  gpx_sync #(.WIDTH(2), .RST_VAL(1'b1)) i_busSync (
    .clk(clk), .rstN(rstN), .d({sclIn, sdaIn}), .q({sclS, sdaS})
  );

  gpx_sync #(.WIDTH(NUM_PINS), .RST_VAL(1'b0)) i_pinSync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(pinSync)
  );

  gpx_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .rdByte(rdByte), .stb(stb), .sdaOe(sdaOe)
  );

  gpx_datapath #(.NUM_PINS(NUM_PINS)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .pinSync(pinSync),
    .rdByte(rdByte), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: tb/test_gpio_expander_i2c.sv
`timescale 1ns/1ps
module test_gpio_expander_i2c;
  localparam int         N    = 16;
  localparam int         B    = N / 8;
  localparam int         SH   = 1;
  localparam int         Q    = 10;
  localparam logic [6:0] ADDR = 7'h41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, irqOut;
  logic [N-1:0] pinOut, pinOe, pinIn, extPins;
  logic [N-1:0] dirM, outM, ieM, statM;
  logic sdaLine;
  int   nChecks = 0, nFails = 0, r11Viol = 0;
  logic oePrev = 1'b0, sclPrevM = 1'b1, done = 1'b0;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;
  assign pinIn   = (pinOe & pinOut) | (~pinOe & extPins);

  gpio_expander_i2c #(.NUM_PINS(N), .DEV_ADDR(ADDR)) i_gpio_expander_i2c (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // R11 monitor: drive changes while SCL is high are violations
  always @(negedge clk) begin
    if (rstN && (sdaOe !== oePrev) && sclM && sclPrevM) r11Viol++;
    oePrev   <= sdaOe;
    sclPrevM <= sclM;
  end

  function automatic logic [N-1:0] lvl();
    return (dirM & outM) | (~dirM & extPins);
  endfunction

  function automatic logic [7:0] expRead(int off);
    int fn  = off >> SH;
    int idx = off & (B - 1);
    case (fn)
      0: return dirM[idx*8 +: 8];
      1: return lvl() >> (idx*8);
      2: return ieM[idx*8 +: 8];
      3: return statM[idx*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelWrite(int off, logic [7:0] v);
    int fn  = off >> SH;
    int idx = off & (B - 1);
    logic [N-1:0] old = lvl();
    case (fn)
      0: dirM[idx*8 +: 8] = v;
      1: outM[idx*8 +: 8] = v;
      2: ieM[idx*8 +: 8]  = v;
      default: ;
    endcase
    statM = statM | (old ^ lvl());
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = v[i]; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); ack = ~sdaLine; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(logic last, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q); v[i] = sdaLine; tick(Q); sclM = 1'b0;
    end
    tick(Q); sdaM = last; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q); sdaM = 1'b1;
  endtask

  task automatic wrBytes(int off, int n, logic [7:0] b0, logic [7:0] b1);
    logic ack;
    busStart();
    sendByte({ADDR, 1'b0}, ack); chk("R2 address ack", ack, 1'b1);
    sendByte(8'(off), ack);
    sendByte(b0, ack); modelWrite(off, b0);
    if (n > 1) begin sendByte(b1, ack); modelWrite(off + 1, b1); end
    busStop(); tick(10);
  endtask

  task automatic rdBytes(int off, int n, string req);
    logic ack;
    logic [7:0] v;
    logic [7:0] e;
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'(off), ack);
    busStart();
    sendByte({ADDR, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      e = expRead(off + i);
      if (((off + i) >> SH) == 3) statM[((off + i) & (B-1))*8 +: 8] = 8'h00;
      recvByte(i == n - 1, v);
      chk(req, v, e);
    end
    busStop(); tick(10);
  endtask

  task automatic setExt(logic [N-1:0] v);
    logic [N-1:0] old = lvl();
    extPins = v;
    tick(10);
    statM = statM | (old ^ lvl());
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic ack;
    int   r, off;
    void'($urandom(32'd2024));
    dirM = '0; outM = '0; ieM = '0; statM = '0;
    extPins = 16'hA5C3;
    tick(5); rstN = 1'b1; tick(10);

    // R1 reset state
    chk("R1 pinOe", pinOe, '0);
    chk("R1 pinOut", pinOut, '0);
    chk("R1 irqOut", irqOut, 1'b0);
    rdBytes(4, 2, "R1 enables");
    // R12 no status from levels present at reset release
    rdBytes(6, 2, "R12 status after reset");

    // R2 foreign address: no ack, no effect
    busStart(); sendByte({7'h22, 1'b0}, ack); chk("R2 foreign nack", ack, 1'b0);
    sendByte(8'h00, ack); sendByte(8'hFF, ack); busStop(); tick(10);
    chk("R2 foreign no effect", pinOe, '0);

    // R4 direction, R3 byte placement
    wrBytes(0, 1, 8'h0F, 8'h00);
    chk("R4 pinOe low byte", pinOe, 16'h000F);
    wrBytes(1, 1, 8'h80, 8'h00);
    chk("R3 pin 15 in byte 1 bit 7", pinOe, 16'h800F);
    // R5 output drive and level readback
    wrBytes(2, 1, 8'h5A, 8'h00);
    chk("R5 pinOut", pinOut, 16'h005A);
    rdBytes(2, 1, "R5 level read byte 0");
    rdBytes(3, 1, "R5 level read byte 1");
    rdBytes(6, 2, "R6 status after direction change");

    // R10 burst write and burst read
    wrBytes(4, 2, 8'h30, 8'h01);
    rdBytes(4, 2, "R10 burst enable readback");
    rdBytes(0, 2, "R10 burst direction readback");

    // R6/R8 change on an enabled input raises the request
    setExt(extPins ^ 16'h0010);
    chk("R8 irq on enabled change", irqOut, |(statM & ieM));
    chk("R6 expected status set", statM[4], 1'b1);
    // R6 status ignores writes
    wrBytes(6, 1, 8'h00, 8'h00);
    chk("R6 irq survives status write", irqOut, 1'b1);
    // R7 read clears
    rdBytes(6, 1, "R7 status read");
    rdBytes(6, 1, "R7 status cleared");
    chk("R8 irq after clear", irqOut, |(statM & ieM));

    // R9 reserved and out-of-map offsets
    wrBytes(8, 2, 8'hFF, 8'hFF);
    chk("R9 reserved write ignored", pinOe, dirM);
    rdBytes(8, 1, "R9 reserved bank reads zero");
    rdBytes(12, 1, "R9 beyond map reads zero");
    rdBytes(200, 1, "R9 far offset reads zero");

    // random mix
    for (int i = 0; i < 30; i++) begin
      r   = $urandom_range(0, 2);
      off = $urandom_range(0, 11);
      case (r)
        0: wrBytes(off, 1, 8'($urandom), 8'h00);
        1: setExt(N'($urandom));
        default: rdBytes(off, 1, "R3 R5 random read");
      endcase
      chk("R4 random pinOe", pinOe, dirM);
      chk("R8 random irq", irqOut, |(statM & ieM));
    end

    chk("R11 SDA drive changes with SCL high", r11Viol, 0);
    finishRun();
  end
endmodule